// File: doc/BRIEF.md
# Coherence Execute-Stage Update Logic

This block is the execute stage of an L1 coherence controller. Each cycle it may receive one request. For that request it takes three things: the decision bits already computed by the protocol table, the per-way results of the set snoop (tags, read/write privileges, coherence states, hit and hit way), and the way picked by the least-recently-used policy. From these it produces the update commands that the rest of the cache needs.

It decides whether a valid block must be evicted to make room. When one is, it rebuilds the victim's block address and reports the victim's state. It then issues a command and target way to the data cache and a write to the coherence-state array. It also sends snooped data to the message stage, and it writes the miss-status table. That table write covers the protocol's allocate, update and release commands. It also covers the pre-allocation of an entry flagged as waiting for eviction whenever a replacement happens.

All results are registered once, so they appear one clock after the request is presented. Every enable is gated by the request-valid bit, so an empty pipeline slot updates nothing.

Top module: `coh_exec_update`

## Requirements
- R1: The victim counts as valid when the LRU way has its read or write privilege bit set. A replacement happens only when all of these hold: the request is valid, the protocol writes data into the cache, the snoop missed, and the victim is valid.
- R2: On a replacement, the victim address is {snoop tag of the LRU way, set index of the request, all-zero offset}. The request address is laid out as {tag, set, offset}, with the offset in the low bits. The victim state is the coherence state of the LRU way.
- R3: The data-cache command is encoded 2'b10 for replacement, 2'b01 for info-and-data update and 2'b00 for info-only update. The choices are taken in that priority: replacement first, then info-and-data if the protocol writes data, otherwise info-only. The value 2'b11 never appears.
- R4: Both the data-cache target way and the coherence-state target way are the snoop hit way when the snoop hit, and the LRU way when it missed.
- R5: The data-cache update is valid when the request is valid and either the protocol writes data, or the protocol updates privileges and the snoop hit.
- R6: The coherence-state write is enabled when the request is valid, the next state is stable, and either the snoop hit or the protocol writes data. The write carries the request's set index and the protocol's next state.
- R7: Snoop data is forwarded when the request is valid and the protocol asks to send data from the cache. The forward carries the request's set index and the snoop hit way.
- R8: The miss-status table is written when the request is valid and any of these holds: allocate, update, release, or a replacement. The entry index is the table hit index on a table hit, and the free index otherwise. The waiting-for-eviction bit is set exactly when a replacement happens.
- R9: All outputs appear one clock after their inputs. A cycle with request-valid low produces no enable on any output. During reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request occupies this stage |
| req_addr | input | TAG_W+SET_W+OFF_W | Request block address {tag, set, offset} |
| pr_write_data | input | 1 | Protocol writes data into the cache |
| pr_update_priv | input | 1 | Protocol updates privileges |
| pr_next_stable | input | 1 | Next coherence state is stable |
| pr_send_data | input | 1 | Protocol sends data from the cache |
| pr_mshr_alloc | input | 1 | Protocol allocates a table entry |
| pr_mshr_update | input | 1 | Protocol updates a table entry |
| pr_mshr_release | input | 1 | Protocol releases a table entry |
| pr_next_state | input | STATE_W | Next coherence state |
| snoop_tags | input | WAYS*TAG_W | Per-way tags, way 0 in the low bits |
| snoop_can_read | input | WAYS | Per-way read privilege |
| snoop_can_write | input | WAYS | Per-way write privilege |
| snoop_states | input | WAYS*STATE_W | Per-way coherence states, way 0 in the low bits |
| snoop_hit | input | 1 | Tag matched a valid way |
| snoop_hit_way | input | log2(WAYS) | Matching way |
| lru_way | input | log2(WAYS) | Least-recently-used way |
| mshr_hit | input | 1 | Request found in the miss-status table |
| mshr_hit_idx | input | MSHR_W | Index of the matching entry |
| mshr_free_idx | input | MSHR_W | Index of a free entry |
| repl_o | output | 1 | Replacement happens |
| victim_addr_o | output | TAG_W+SET_W+OFF_W | Rebuilt victim address |
| victim_state_o | output | STATE_W | Victim coherence state |
| dc_valid_o | output | 1 | Data-cache update valid |
| dc_cmd_o | output | 2 | Data-cache command |
| dc_way_o | output | log2(WAYS) | Data-cache target way |
| cs_wen_o | output | 1 | Coherence-state write enable |
| cs_set_o | output | SET_W | Coherence-state set index |
| cs_way_o | output | log2(WAYS) | Coherence-state way |
| cs_state_o | output | STATE_W | Coherence state written |
| fwd_valid_o | output | 1 | Snoop-data forward valid |
| fwd_set_o | output | SET_W | Forwarded set index |
| fwd_way_o | output | log2(WAYS) | Forwarded way |
| mshr_wen_o | output | 1 | Miss-status table write |
| mshr_idx_o | output | MSHR_W | Entry written |
| mshr_wait_evict_o | output | 1 | Entry waits for eviction |

## Verification
The embedded properties hold on every cycle. They check that an empty slot leaves every enable low, and that a snoop hit can never lead to a replacement. They check that a replacement always comes with the replacement command, a table write and the waiting-for-eviction flag, and that the reserved command code never appears. Only the scenario-driven scoreboard can confirm the data values. Those are the rebuilt victim address taken from the correct LRU tag, the hit-versus-LRU way selection, the table index choice, and the privilege-only versus data-write distinction. It checks them across directed corner cases (read-only, write-only and invalid victims, bubbles with all decision bits high) and a long stream of random requests.

// File: rtl/coh_exec_update.sv
module coh_exec_update #(
  parameter int WAYS    = 4,
  parameter int TAG_W   = 8,
  parameter int SET_W   = 4,
  parameter int OFF_W   = 3,
  parameter int STATE_W = 3,
  parameter int MSHR_W  = 3,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int ADDR_W = TAG_W + SET_W + OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    pr_write_data,
  input  logic                    pr_update_priv,
  input  logic                    pr_next_stable,
  input  logic                    pr_send_data,
  input  logic                    pr_mshr_alloc,
  input  logic                    pr_mshr_update,
  input  logic                    pr_mshr_release,
  input  logic [STATE_W-1:0]      pr_next_state,
  input  logic [WAYS*TAG_W-1:0]   snoop_tags,
  input  logic [WAYS-1:0]         snoop_can_read,
  input  logic [WAYS-1:0]         snoop_can_write,
  input  logic [WAYS*STATE_W-1:0] snoop_states,
  input  logic                    snoop_hit,
  input  logic [WAY_W-1:0]        snoop_hit_way,
  input  logic [WAY_W-1:0]        lru_way,
  input  logic                    mshr_hit,
  input  logic [MSHR_W-1:0]       mshr_hit_idx,
  input  logic [MSHR_W-1:0]       mshr_free_idx,
  output logic                    repl_o,
  output logic [ADDR_W-1:0]       victim_addr_o,
  output logic [STATE_W-1:0]      victim_state_o,
  output logic                    dc_valid_o,
  output logic [1:0]              dc_cmd_o,
  output logic [WAY_W-1:0]        dc_way_o,
  output logic                    cs_wen_o,
  output logic [SET_W-1:0]        cs_set_o,
  output logic [WAY_W-1:0]        cs_way_o,
  output logic [STATE_W-1:0]      cs_state_o,
  output logic                    fwd_valid_o,
  output logic [SET_W-1:0]        fwd_set_o,
  output logic [WAY_W-1:0]        fwd_way_o,
  output logic                    mshr_wen_o,
  output logic [MSHR_W-1:0]       mshr_idx_o,
  output logic                    mshr_wait_evict_o
);

  localparam logic [1:0] CMD_INFO      = 2'b00;
  localparam logic [1:0] CMD_INFO_DATA = 2'b01;
  localparam logic [1:0] CMD_REPL      = 2'b10;

  logic [SET_W-1:0]   req_set;
  logic [TAG_W-1:0]   lru_tag;
  logic [STATE_W-1:0] lru_state;
  logic               victim_ok;
  logic               do_repl;
  logic [WAY_W-1:0]   tgt_way;
  logic [1:0]         cmd;

  assign req_set   = req_addr[OFF_W +: SET_W];
  assign lru_tag   = snoop_tags[lru_way*TAG_W +: TAG_W];
  assign lru_state = snoop_states[lru_way*STATE_W +: STATE_W];
  assign victim_ok = snoop_can_read[lru_way] | snoop_can_write[lru_way];
  assign do_repl   = req_valid & pr_write_data & ~snoop_hit & victim_ok;
  assign tgt_way   = snoop_hit ? snoop_hit_way : lru_way;
  assign cmd       = do_repl ? CMD_REPL : (pr_write_data ? CMD_INFO_DATA : CMD_INFO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      repl_o            <= 1'b0;
      victim_addr_o     <= '0;
      victim_state_o    <= '0;
      dc_valid_o        <= 1'b0;
      dc_cmd_o          <= CMD_INFO;
      dc_way_o          <= '0;
      cs_wen_o          <= 1'b0;
      cs_set_o          <= '0;
      cs_way_o          <= '0;
      cs_state_o        <= '0;
      fwd_valid_o       <= 1'b0;
      fwd_set_o         <= '0;
      fwd_way_o         <= '0;
      mshr_wen_o        <= 1'b0;
      mshr_idx_o        <= '0;
      mshr_wait_evict_o <= 1'b0;
    end else begin
      repl_o            <= do_repl;
      victim_addr_o     <= {lru_tag, req_set, {OFF_W{1'b0}}};
      victim_state_o    <= lru_state;
      dc_valid_o        <= req_valid & ((pr_update_priv & snoop_hit) | pr_write_data);
      dc_cmd_o          <= cmd;
      dc_way_o          <= tgt_way;
      cs_wen_o          <= req_valid & pr_next_stable & (snoop_hit | pr_write_data);
      cs_set_o          <= req_set;
      cs_way_o          <= tgt_way;
      cs_state_o        <= pr_next_state;
      fwd_valid_o       <= req_valid & pr_send_data;
      fwd_set_o         <= req_set;
      fwd_way_o         <= snoop_hit_way;
      mshr_wen_o        <= req_valid & (pr_mshr_alloc | pr_mshr_update | pr_mshr_release | do_repl);
      mshr_idx_o        <= mshr_hit ? mshr_hit_idx : mshr_free_idx;
      mshr_wait_evict_o <= do_repl;
    end
  end

  assert_hit_never_evicts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && snoop_hit) |=> !repl_o);

  assert_victim_offset_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    repl_o |-> (victim_addr_o[OFF_W-1:0] == '0));

  assert_repl_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    repl_o |-> (dc_valid_o && dc_cmd_o == CMD_REPL));

  assert_cmd_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dc_cmd_o != 2'b11);

  assert_repl_prealloc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    repl_o |-> (mshr_wen_o && mshr_wait_evict_o));

  assert_wait_evict_only_repl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mshr_wait_evict_o |-> repl_o);

  assert_bubble_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(repl_o || dc_valid_o || cs_wen_o || fwd_valid_o || mshr_wen_o));

endmodule

// File: tb/test_coh_exec_update.sv
`timescale 1ns/1ps
module test_coh_exec_update;
  localparam int WAYS = 4, TAG_W = 8, SET_W = 4, OFF_W = 3, STATE_W = 3, MSHR_W = 3;
  localparam int WAY_W = 2, ADDR_W = TAG_W + SET_W + OFF_W;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 0, pr_write_data = 0, pr_update_priv = 0, pr_next_stable = 0;
  logic pr_send_data = 0, pr_mshr_alloc = 0, pr_mshr_update = 0, pr_mshr_release = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [STATE_W-1:0] pr_next_state = '0;
  logic [WAYS*TAG_W-1:0] snoop_tags = '0;
  logic [WAYS-1:0] snoop_can_read = '0, snoop_can_write = '0;
  logic [WAYS*STATE_W-1:0] snoop_states = '0;
  logic snoop_hit = 0, mshr_hit = 0;
  logic [WAY_W-1:0] snoop_hit_way = '0, lru_way = '0;
  logic [MSHR_W-1:0] mshr_hit_idx = '0, mshr_free_idx = '0;

  logic repl_o, dc_valid_o, cs_wen_o, fwd_valid_o, mshr_wen_o, mshr_wait_evict_o;
  logic [ADDR_W-1:0] victim_addr_o;
  logic [STATE_W-1:0] victim_state_o, cs_state_o;
  logic [1:0] dc_cmd_o;
  logic [WAY_W-1:0] dc_way_o, cs_way_o, fwd_way_o;
  logic [SET_W-1:0] cs_set_o, fwd_set_o;
  logic [MSHR_W-1:0] mshr_idx_o;

  coh_exec_update i_coh_exec_update (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .pr_write_data(pr_write_data), .pr_update_priv(pr_update_priv),
    .pr_next_stable(pr_next_stable), .pr_send_data(pr_send_data),
    .pr_mshr_alloc(pr_mshr_alloc), .pr_mshr_update(pr_mshr_update),
    .pr_mshr_release(pr_mshr_release), .pr_next_state(pr_next_state),
    .snoop_tags(snoop_tags), .snoop_can_read(snoop_can_read),
    .snoop_can_write(snoop_can_write), .snoop_states(snoop_states),
    .snoop_hit(snoop_hit), .snoop_hit_way(snoop_hit_way), .lru_way(lru_way),
    .mshr_hit(mshr_hit), .mshr_hit_idx(mshr_hit_idx), .mshr_free_idx(mshr_free_idx),
    .repl_o(repl_o), .victim_addr_o(victim_addr_o), .victim_state_o(victim_state_o),
    .dc_valid_o(dc_valid_o), .dc_cmd_o(dc_cmd_o), .dc_way_o(dc_way_o),
    .cs_wen_o(cs_wen_o), .cs_set_o(cs_set_o), .cs_way_o(cs_way_o),
    .cs_state_o(cs_state_o), .fwd_valid_o(fwd_valid_o), .fwd_set_o(fwd_set_o),
    .fwd_way_o(fwd_way_o), .mshr_wen_o(mshr_wen_o), .mshr_idx_o(mshr_idx_o),
    .mshr_wait_evict_o(mshr_wait_evict_o));

  typedef struct packed {
    logic repl; logic [ADDR_W-1:0] vaddr; logic [STATE_W-1:0] vstate;
    logic dcv; logic [1:0] cmd; logic [WAY_W-1:0] dway;
    logic csw; logic [SET_W-1:0] cset; logic [WAY_W-1:0] cway; logic [STATE_W-1:0] cstate;
    logic fv; logic [SET_W-1:0] fset; logic [WAY_W-1:0] fway;
    logic mw; logic [MSHR_W-1:0] midx; logic mwe;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // staged stimulus, copied onto the inputs at a falling edge
  logic s_v, s_wd, s_up, s_st, s_sd, s_al, s_ud, s_rl, s_hit, s_mh;
  logic [ADDR_W-1:0] s_addr;
  logic [STATE_W-1:0] s_next;
  logic [WAYS*TAG_W-1:0] s_tags;
  logic [WAYS-1:0] s_rd, s_wr;
  logic [WAYS*STATE_W-1:0] s_states;
  logic [WAY_W-1:0] s_hw, s_lw;
  logic [MSHR_W-1:0] s_mhi, s_mfi;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t model();
    exp_t e;
    logic vok, hit_way_sel;
    logic [WAY_W-1:0] tw;
    vok = s_rd[s_lw] | s_wr[s_lw];                          // R1
    e.repl = s_v & s_wd & ~s_hit & vok;
    e.vaddr = {s_tags[s_lw*TAG_W +: TAG_W], s_addr[OFF_W +: SET_W], 3'b000}; // R2
    e.vstate = s_states[s_lw*STATE_W +: STATE_W];
    e.cmd = e.repl ? 2'b10 : (s_wd ? 2'b01 : 2'b00);       // R3
    hit_way_sel = s_hit;
    tw = hit_way_sel ? s_hw : s_lw;                          // R4
    e.dway = tw; e.cway = tw;
    e.dcv = s_v & ((s_up & s_hit) | s_wd);                   // R5
    e.csw = s_v & s_st & (s_hit | s_wd);                     // R6
    e.cset = s_addr[OFF_W +: SET_W]; e.cstate = s_next;
    e.fv = s_v & s_sd;                                       // R7
    e.fset = s_addr[OFF_W +: SET_W]; e.fway = s_hw;
    e.mw = s_v & (s_al | s_ud | s_rl | e.repl);              // R8
    e.midx = s_mh ? s_mhi : s_mfi;
    e.mwe = e.repl;
    return e;
  endfunction

  task automatic drive();
    @(negedge clk);
    req_valid = s_v; pr_write_data = s_wd; pr_update_priv = s_up; pr_next_stable = s_st;
    pr_send_data = s_sd; pr_mshr_alloc = s_al; pr_mshr_update = s_ud; pr_mshr_release = s_rl;
    req_addr = s_addr; pr_next_state = s_next; snoop_tags = s_tags;
    snoop_can_read = s_rd; snoop_can_write = s_wr; snoop_states = s_states;
    snoop_hit = s_hit; snoop_hit_way = s_hw; lru_way = s_lw;
    mshr_hit = s_mh; mshr_hit_idx = s_mhi; mshr_free_idx = s_mfi;
    q.push_back(model());
  endtask

  task automatic clear_ctl();
    {s_v, s_wd, s_up, s_st, s_sd, s_al, s_ud, s_rl, s_hit, s_mh} = '0;
  endtask

  // monitor: one cycle after each driven request, compare the registered outputs
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R1 repl", 32'(repl_o), 32'(e.repl));
      chk("R5 dc_valid", 32'(dc_valid_o), 32'(e.dcv));
      chk("R6 cs_wen", 32'(cs_wen_o), 32'(e.csw));
      chk("R7 fwd_valid", 32'(fwd_valid_o), 32'(e.fv));
      chk("R8 mshr_wen", 32'(mshr_wen_o), 32'(e.mw));
      chk("R8 wait_evict", 32'(mshr_wait_evict_o), 32'(e.mwe));
      if (e.repl) begin
        chk("R2 victim_addr", 32'(victim_addr_o), 32'(e.vaddr));
        chk("R2 victim_state", 32'(victim_state_o), 32'(e.vstate));
      end
      if (e.dcv) begin
        chk("R3 dc_cmd", 32'(dc_cmd_o), 32'(e.cmd));
        chk("R4 dc_way", 32'(dc_way_o), 32'(e.dway));
      end
      if (e.csw) begin
        chk("R4 cs_way", 32'(cs_way_o), 32'(e.cway));
        chk("R6 cs_set", 32'(cs_set_o), 32'(e.cset));
        chk("R6 cs_state", 32'(cs_state_o), 32'(e.cstate));
      end
      if (e.fv) begin
        chk("R7 fwd_set", 32'(fwd_set_o), 32'(e.fset));
        chk("R7 fwd_way", 32'(fwd_way_o), 32'(e.fway));
      end
      if (e.mw) chk("R8 mshr_idx", 32'(mshr_idx_o), 32'(e.midx));
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_ctl();
    s_addr = 15'h5A3C; s_next = 3'd5;
    s_tags = {8'hD4, 8'hC3, 8'hB2, 8'hA1};
    s_states = {3'd4, 3'd3, 3'd2, 3'd1};
    s_rd = 4'b0000; s_wr = 4'b0000; s_hw = 2'd0; s_lw = 2'd0;
    s_mhi = 3'd6; s_mfi = 3'd2;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset enables", 32'({repl_o, dc_valid_o, cs_wen_o, fwd_valid_o, mshr_wen_o, mshr_wait_evict_o}), 32'd0);
    chk("R9 reset victim_addr", 32'(victim_addr_o), 32'd0);
    chk("R9 reset dc_cmd", 32'(dc_cmd_o), 32'd0);
    rst_n = 1'b1;

    // R4 R5 R6 hit with privilege update only
    clear_ctl(); s_v = 1; s_up = 1; s_st = 1; s_hit = 1; s_hw = 2'd3; s_lw = 2'd1;
    s_rd = 4'b1111; drive();
    // R1 R2 R3 R8 miss writing data with read-only victim at way 2
    clear_ctl(); s_v = 1; s_wd = 1; s_st = 1; s_al = 1; s_lw = 2'd2; s_hw = 2'd0;
    s_rd = 4'b0100; s_wr = 4'b0000; drive();
    // R1 write-only victim at way 1, table hit index
    clear_ctl(); s_v = 1; s_wd = 1; s_lw = 2'd1; s_rd = 4'b0000; s_wr = 4'b0010;
    s_mh = 1; drive();
    // R1 R3 invalid victim: no replacement, info-and-data command
    clear_ctl(); s_v = 1; s_wd = 1; s_st = 1; s_lw = 2'd3; s_rd = 4'b0111; s_wr = 4'b0111;
    drive();
    // R5 privilege update on a miss yields no data-cache update
    clear_ctl(); s_v = 1; s_up = 1; s_st = 1; s_lw = 2'd0; drive();
    // R7 send data, R8 release on table hit
    clear_ctl(); s_v = 1; s_sd = 1; s_hit = 1; s_hw = 2'd2; s_rl = 1; s_mh = 1;
    s_addr = 15'h1F47; drive();
    // R9 bubble with every decision bit high
    clear_ctl(); s_wd = 1; s_up = 1; s_st = 1; s_sd = 1; s_al = 1; s_ud = 1; s_rl = 1;
    s_rd = 4'b1111; drive();
    // R3 hit writing data: info-and-data, not replacement
    clear_ctl(); s_v = 1; s_wd = 1; s_hit = 1; s_hw = 2'd1; s_st = 1; s_ud = 1; drive();

    for (int i = 0; i < 600; i++) begin
      logic [31:0] r0, r1, r2;
      r0 = $urandom; r1 = $urandom; r2 = $urandom;
      s_v = (r0[3:0] != 0); s_wd = r0[4]; s_up = r0[5]; s_st = r0[6]; s_sd = r0[7];
      s_al = r0[8]; s_ud = r0[9] & r0[10]; s_rl = r0[11] & r0[12]; s_hit = r0[13];
      s_mh = r0[14]; s_hw = r0[16:15]; s_lw = r0[18:17]; s_mhi = r0[21:19];
      s_mfi = r0[24:22]; s_next = r0[27:25]; s_rd = r1[3:0]; s_wr = r1[7:4];
      s_addr = r1[22:8]; s_tags = r2; s_states = r1[31:20];
      drive();
    end
    clear_ctl(); drive();
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule